// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. Software programs a reload count, a timeout routing choice and suspend options into a 16-bit control register, then sets a run bit. From then on the block counts down once for each half-second tick it receives. To keep it from expiring, software must write an ordered pair of key words to the service register. If the count reaches zero, the block drives either its internal-reset output or its external-reset output for a fixed number of clock cycles. It then stays expired until the next system reset.

Two active-low control bits act at once, whatever the state of the counter. One bit fires a fixed-length internal-reset pulse. The other holds the external-reset output asserted for as long as the bit is written low. Two further bits freeze the countdown while the chip reports low-power or debug state.

Control register layout (bus address 0):
- bits [15:8]: reload count N.
- bit 7: run.
- bit 6: route timeout to the external output when 1.
- bit 5: software reset, active low, reads back 1.
- bit 4: external assert, active low.
- bit 3: freeze in low-power state.
- bit 2: freeze in debug state.

The service register is at address 1 and reads as 0.

Top module: `wdog_keyed_svc`

## Requirements
- R1: After reset both reset outputs are low and the control register reads 16'h0030.
- R2: Once the run bit (bit 7) is written 1, a later control write with bit 7 at 0 does not clear it; only the system reset clears it.
- R3: With reload count N, the timeout output asserts right after the (N+1)-th counted tick since start or the last reload, and not earlier.
- R4: Writing 16'h5555 and then 16'hAAAA to the service register reloads the count to N+1 ticks. Repeated 16'h5555 words before the 16'hAAAA still arm the sequence.
- R5: A 16'hAAAA that is not directly preceded by 16'h5555, or a sequence broken by any other service word, does not reload the count.
- R6: Writing 0 to control bit 5 drives the internal-reset output high for PULSE_CYC cycles, starting the cycle after the write. Writing 1 to it has no effect. Bit 5 always reads 1.
- R7: While control bit 4 holds 0, the external-reset output is high. Writing it back to 1 releases the output.
- R8: A timeout drives the internal-reset output when bit 6 is 0 and the external-reset output when bit 6 is 1. The other output stays low.
- R9: Ticks are not counted while low-power state is present with bit 3 set, or while debug state is present with bit 2 set. A state input whose freeze bit is clear does not stop the count.
- R10: A new reload count written while the watchdog runs does not change the count in progress. It takes effect at the next reload.
- R11: A timeout pulse lasts exactly PULSE_CYC cycles. After it, the counter stays stopped: further ticks and service writes produce no new pulse until reset.
- R12: Ticks have no effect while the run bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tick_i | input | 1 | One-cycle pulse per half second |
| low_power_i | input | 1 | Chip is in low-power state |
| debug_i | input | 1 | Chip is halted for debug |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register address (0 control, 1 service) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register |
| rst_int_o | output | 1 | Internal reset request, active high |
| rst_ext_o | output | 1 | External reset request, active high |

## Verification
The bench targets the smallest timeout (N = 0, a single tick). A counter that is off by one there either fires with no tick at all or needs two. It sends a lone 16'hAAAA, a sequence broken by a foreign word, and a repeated 16'h5555. A key detector that only looks at the last word would reload on the first two, and one that resets on any repeat would miss the third. It rewrites the reload count in mid-run and checks that the timeout still lands on the old count, which catches a counter that reads the field live. It also checks that the run bit cannot be cleared, that the pulse has its exact length, that the counter stays stopped after expiry, and that each freeze bit only applies together with its own state input.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W    = 16;
  localparam int TMO_W    = 8;
  localparam int TMO_LSB  = 8;
  localparam int B_RUN    = 7;
  localparam int B_SEL    = 6;
  localparam int B_SWRSTN = 5;
  localparam int B_EXTN   = 4;
  localparam int B_FRZ_LP = 3;
  localparam int B_FRZ_DB = 2;
  localparam int CTRL_OFS = 0;
  localparam int SVC_OFS  = 1;
  localparam logic [REG_W-1:0] KEY_ARM  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_FIRE = 16'hAAAA;

  typedef enum logic {KEY_IDLE, KEY_ARMED} key_state_e;

  typedef struct packed {
    logic [TMO_W-1:0] tmo;
    logic             run;
    logic             sel_ext;
    logic             ext_n;
    logic             frz_lp;
    logic             frz_db;
  } ctrl_t;
endpackage

// File: rtl/wdog_ctrl_regs.sv
module wdog_ctrl_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int PULSE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output ctrl_t             ctrl_o,
  output logic              sw_rst_o
);
  localparam int PLS_W = $clog2(PULSE_CYC + 1);

  ctrl_t            ctrl_q, ctrl_d;
  logic [PLS_W-1:0] sw_cnt_q, sw_cnt_d;
  logic             ctrl_wr, sw_cnt_en;
  logic [1:0]       unused_low;

  assign ctrl_wr    = wr_i && (addr_i == ADDR_W'(CTRL_OFS));
  assign unused_low = wdata_i[1:0];

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.tmo     = wdata_i[TMO_LSB +: TMO_W];
      ctrl_d.run     = ctrl_q.run | wdata_i[B_RUN];
      ctrl_d.sel_ext = wdata_i[B_SEL];
      ctrl_d.ext_n   = wdata_i[B_EXTN];
      ctrl_d.frz_lp  = wdata_i[B_FRZ_LP];
      ctrl_d.frz_db  = wdata_i[B_FRZ_DB];
    end
  end

  always_comb begin
    sw_cnt_en = 1'b0;
    sw_cnt_d  = sw_cnt_q;
    if (ctrl_wr && !wdata_i[B_SWRSTN]) begin
      sw_cnt_en = 1'b1;
      sw_cnt_d  = PLS_W'(PULSE_CYC);
    end else if (sw_cnt_q != '0) begin
      sw_cnt_en = 1'b1;
      sw_cnt_d  = sw_cnt_q - PLS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.tmo     <= '0;
      ctrl_q.run     <= 1'b0;
      ctrl_q.sel_ext <= 1'b0;
      ctrl_q.ext_n   <= 1'b1;
      ctrl_q.frz_lp  <= 1'b0;
      ctrl_q.frz_db  <= 1'b0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sw_cnt_q <= '0;
    else if (sw_cnt_en) sw_cnt_q <= sw_cnt_d;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CTRL_OFS)) begin
      rdata_o[TMO_LSB +: TMO_W] = ctrl_q.tmo;
      rdata_o[B_RUN]    = ctrl_q.run;
      rdata_o[B_SEL]    = ctrl_q.sel_ext;
      rdata_o[B_SWRSTN] = 1'b1;
      rdata_o[B_EXTN]   = ctrl_q.ext_n;
      rdata_o[B_FRZ_LP] = ctrl_q.frz_lp;
      rdata_o[B_FRZ_DB] = ctrl_q.frz_db;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign sw_rst_o = (sw_cnt_q != '0);

  // R2: the run bit never falls outside reset
  p_run_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.run |=> ctrl_q.run);

  // R6: a software reset write raises the request on the next cycle
  p_swrst_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata_i[B_SWRSTN]) |=> sw_rst_o);
endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             reload_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (svc_wr_i) begin
      if (wdata_i == KEY_ARM) state_d = KEY_ARMED;
      else                    state_d = KEY_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= KEY_IDLE;
    else if (svc_wr_i) state_q <= state_d;
  end

  assign reload_o = svc_wr_i && (wdata_i == KEY_FIRE) && (state_q == KEY_ARMED);

  // R5: any service word other than the arming key leaves the sequence unarmed
  p_foreign_word_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr_i && wdata_i != KEY_ARM) |=> (state_q == KEY_IDLE));
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import wdog_pkg::*;
#(
  parameter int PULSE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic             tick_i,
  input  logic             freeze_i,
  input  logic             reload_i,
  output logic             fire_o
);
  localparam int CNT_W = TMO_W + 1;
  localparam int PLS_W = $clog2(PULSE_CYC + 1);

  logic             live_q, live_d;
  logic             expired_q, expired_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PLS_W-1:0] pls_q, pls_d;
  logic [CNT_W-1:0] full_cnt;
  logic             cnt_en, pls_en;

  assign full_cnt = {1'b0, tmo_i} + CNT_W'(1);

  always_comb begin
    live_d    = live_q | run_i;
    expired_d = expired_q;
    cnt_en    = 1'b0;
    cnt_d     = cnt_q;
    pls_en    = (pls_q != '0);
    pls_d     = (pls_q != '0) ? pls_q - PLS_W'(1) : pls_q;
    if (!live_q) begin
      cnt_en = 1'b1;
      cnt_d  = full_cnt;
    end else if (!expired_q) begin
      if (reload_i) begin
        cnt_en = 1'b1;
        cnt_d  = full_cnt;
      end else if (tick_i && !freeze_i) begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          expired_d = 1'b1;
          pls_en    = 1'b1;
          pls_d     = PLS_W'(PULSE_CYC);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q    <= 1'b0;
      expired_q <= 1'b0;
    end else begin
      live_q    <= live_d;
      expired_q <= expired_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pls_q <= '0;
    else if (pls_en) pls_q <= pls_d;
  end

  assign fire_o = (pls_q != '0);

  // R11: expiry holds until reset
  p_expiry_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    expired_q |=> expired_q);

  // R4: a reload restores the full count from the field of that cycle
  p_reload_restores_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !expired_q && reload_i) |=> (cnt_q == ({1'b0, $past(tmo_i)} + CNT_W'(1))));

  // R9: a frozen counter does not move without a reload
  p_frozen_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !expired_q && freeze_i && !reload_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_keyed_svc.sv
module wdog_keyed_svc
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int PULSE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              low_power_i,
  input  logic              debug_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic              rst_int_o,
  output logic              rst_ext_o
);
  ctrl_t ctrl;
  logic  sw_rst, svc_wr, reload, freeze, fire;

  assign svc_wr = bus_wr_i && (bus_addr_i == ADDR_W'(SVC_OFS));
  assign freeze = (ctrl.frz_lp && low_power_i) || (ctrl.frz_db && debug_i);

  wdog_ctrl_regs #(.ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .ctrl_o   (ctrl),
    .sw_rst_o (sw_rst)
  );

  wdog_key_seq u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .svc_wr_i (svc_wr),
    .wdata_i  (bus_wdata_i),
    .reload_o (reload)
  );

  wdog_countdown #(.PULSE_CYC(PULSE_CYC)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (ctrl.run),
    .tmo_i    (ctrl.tmo),
    .tick_i   (tick_i),
    .freeze_i (freeze),
    .reload_i (reload),
    .fire_o   (fire)
  );

  assign rst_int_o = sw_rst || (fire && !ctrl.sel_ext);
  assign rst_ext_o = !ctrl.ext_n || (fire && ctrl.sel_ext);

  // R12: with the run bit clear no timeout can begin
  p_idle_no_fire_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !fire) |=> !fire);
endmodule

// File: tb/tb_wdog_keyed_svc.sv
module tb_wdog_keyed_svc;
  localparam int P = 16;

  logic        clk, rst_n, tick, lp, dbg, wr;
  logic [1:0]  addr;
  logic [15:0] wdata, rdata;
  logic        rint, rext;
  int          checks = 0, fails = 0;
  bit          done = 0;

  wdog_keyed_svc #(.ADDR_W(2), .PULSE_CYC(P)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .low_power_i(lp), .debug_i(dbg),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rst_int_o(rint), .rst_ext_o(rext));

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [15:0] cw(int n, bit run, bit sel, bit flp, bit fdb);
    return {n[7:0], run, sel, 1'b1, 1'b1, flp, fdb, 2'b00};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic do_reset();
    rst_n = 0; tick = 0; lp = 0; dbg = 0; wr = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr_reg(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; addr = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic service();
    wr_reg(2'd1, 16'h5555); wr_reg(2'd1, 16'hAAAA);
  endtask

  task automatic pulse_len(bit ext, output int n);
    n = (ext ? rext : rint) ? 1 : 0;
    repeat (P + 4) begin
      @(negedge clk);
      if (ext ? rext : rint) n++;
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd2024));

    // R1 reset state
    do_reset();
    addr = 0; #1;
    chk("R1 ctrl", rdata, 16'h0030);
    chk("R1 outs", {14'd0, rint, rext}, 16'd0);

    // R12 ticks ignored while stopped
    ticks(6);
    chk("R12 no fire", {14'd0, rint, rext}, 16'd0);
    // R3 boundary N=0: one tick fires
    wr_reg(0, cw(0, 1, 0, 0, 0));
    chk("R3 N0 before", {15'd0, rint}, 16'd0);
    ticks(1);
    chk("R3 N0 fire", {15'd0, rint}, 16'd1);

    // R2 sticky run
    do_reset();
    wr_reg(0, cw(3, 1, 0, 0, 0));
    wr_reg(0, cw(3, 0, 0, 0, 0));
    addr = 0; #1;
    chk("R2 run kept", {15'd0, rdata[7]}, 16'd1);

    // R3, R8, R11 with N=3 internal routing
    do_reset();
    wr_reg(0, cw(3, 1, 0, 0, 0));
    ticks(3);
    chk("R3 not yet", {14'd0, rint, rext}, 16'd0);
    ticks(1);
    chk("R8 int route", {14'd0, rint, rext}, 16'b10);
    pulse_len(0, n);
    chk("R11 pulse len", 16'(n), 16'(P));
    ticks(8); service(); ticks(8);
    chk("R11 stopped", {14'd0, rint, rext}, 16'd0);

    // R8 external routing
    do_reset();
    wr_reg(0, cw(1, 1, 1, 0, 0));
    ticks(2);
    chk("R8 ext route", {14'd0, rint, rext}, 16'b01);
    pulse_len(1, n);
    chk("R8 ext pulse len", 16'(n), 16'(P));

    // R4 service reloads
    do_reset();
    wr_reg(0, cw(2, 1, 0, 0, 0));
    ticks(2); service(); ticks(2);
    chk("R4 reloaded", {15'd0, rint}, 16'd0);
    ticks(1);
    chk("R4 fire after reload", {15'd0, rint}, 16'd1);
    // R4 repeated arm word
    do_reset();
    wr_reg(0, cw(2, 1, 0, 0, 0));
    ticks(2); wr_reg(1, 16'h5555); wr_reg(1, 16'h5555); wr_reg(1, 16'hAAAA); ticks(2);
    chk("R4 double arm", {15'd0, rint}, 16'd0);

    // R5 lone fire word
    do_reset();
    wr_reg(0, cw(2, 1, 0, 0, 0));
    ticks(2); wr_reg(1, 16'hAAAA); ticks(1);
    chk("R5 lone AAAA", {15'd0, rint}, 16'd1);
    // R5 broken sequence
    do_reset();
    wr_reg(0, cw(2, 1, 0, 0, 0));
    ticks(2); wr_reg(1, 16'h5555); wr_reg(1, 16'h1234); wr_reg(1, 16'hAAAA); ticks(1);
    chk("R5 broken seq", {15'd0, rint}, 16'd1);

    // R6 software reset
    do_reset();
    wr_reg(0, cw(0, 0, 0, 0, 0));
    chk("R6 no effect for 1", {14'd0, rint, rext}, 16'd0);
    wr_reg(0, cw(0, 0, 0, 0, 0) & ~16'h0020);
    addr = 0; #1;
    chk("R6 reads 1", {15'd0, rdata[5]}, 16'd1);
    pulse_len(0, n);
    chk("R6 pulse len", 16'(n), 16'(P));

    // R7 external assert level
    do_reset();
    wr_reg(0, cw(0, 0, 0, 0, 0) & ~16'h0010);
    ticks(3);
    chk("R7 held", {14'd0, rint, rext}, 16'b01);
    wr_reg(0, cw(0, 0, 0, 0, 0));
    chk("R7 released", {14'd0, rint, rext}, 16'd0);

    // R9 freeze in low power, then debug without its bit
    do_reset();
    wr_reg(0, cw(1, 1, 0, 1, 0));
    lp = 1; ticks(5);
    chk("R9 frozen lp", {15'd0, rint}, 16'd0);
    lp = 0; dbg = 1; ticks(2);
    chk("R9 dbg not armed", {15'd0, rint}, 16'd1);
    do_reset();
    wr_reg(0, cw(1, 1, 0, 0, 1));
    dbg = 1; ticks(5);
    chk("R9 frozen dbg", {15'd0, rint}, 16'd0);
    dbg = 0; ticks(2);
    chk("R9 thaw", {15'd0, rint}, 16'd1);

    // R10 new count waits for reload
    do_reset();
    wr_reg(0, cw(2, 1, 0, 0, 0));
    ticks(1); wr_reg(0, cw(5, 1, 0, 0, 0)); ticks(2);
    chk("R10 old count", {15'd0, rint}, 16'd1);
    do_reset();
    wr_reg(0, cw(2, 1, 0, 0, 0));
    wr_reg(0, cw(5, 1, 0, 0, 0)); service(); ticks(5);
    chk("R10 new count early", {15'd0, rint}, 16'd0);
    ticks(1);
    chk("R10 new count fire", {15'd0, rint}, 16'd1);

    // random: R3 R4 R5 R8 against a bench model
    for (int it = 0; it < 8; it++) begin
      int  nn, cnt;
      bit  sel, armed, fired;
      logic [15:0] w;
      do_reset();
      nn = $urandom_range(0, 5); sel = 1'($urandom % 2);
      wr_reg(0, cw(nn, 1, sel, 0, 0));
      cnt = nn + 1; armed = 0; fired = 0;
      for (int s = 0; s < 40 && !fired; s++) begin
        case ($urandom % 4)
          0, 1: begin
            ticks(1); cnt--;
            if (cnt == 0) fired = 1;
          end
          default: begin
            case ($urandom % 3)
              0: w = 16'h5555;
              1: w = 16'hAAAA;
              default: w = 16'($urandom);
            endcase
            wr_reg(1, w);
            if (w == 16'h5555) armed = 1;
            else if (w == 16'hAAAA && armed) begin cnt = nn + 1; armed = 0; end
            else armed = 0;
          end
        endcase
        chk(sel ? "R8 rand ext" : "R3 rand int", {14'd0, rint, rext},
            fired ? (sel ? 16'b01 : 16'b10) : 16'd0);
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule